// File: doc/BRIEF.md
# Dual-device SPI flash master

This block drives a serial flash bus shared by up to two flash devices. Each device has its own active-low chip select. A host issues single requests through a valid/ready handshake. Each request carries an operation code, an address in one flat space that covers both devices, and one data byte. The block works out which device the address belongs to and translates the address into that device's 24-bit space. It then shifts out a standard flash command in clock mode 0: the clock rests low, data is launched on the falling edge and sampled on the rising edge. When the command finishes, a one-cycle completion pulse returns the read byte and an error flag.

Program and erase requests are guarded by a set of programmable address windows. Each window has an inclusive base, an inclusive limit and an enable. A program or erase that lands inside an enabled window never reaches the bus and completes with the error flag set. Reads are never guarded.

The serial clock is divided from the system clock. A 3-bit rate field picks between two half-period counts. Parameters set the chip-select setup and hold counts, so the integrator can meet the minimum clock-phase and select-timing limits at the system frequency in use.

Top module: `spi_dual_flash_master`

## Requirements
- R1: While reset is high and in the first cycle after it, both chip selects are high, the serial clock is low, `done` is low and `req_ready` is high.
- R2: A flat address below `cfg_split` selects device 0 (`spi_cs_n[0]` low) and sends the address unchanged. Any other address selects device 1 (`spi_cs_n[1]` low) and sends the address minus `cfg_split`, as 24 bits.
- R3: Operation code 00 (read) sends byte 0x03, then the 24-bit address MSB first, then clocks 8 more bits. The 8 bits sampled on those last rising edges are returned on `done_rdata`, with `done_err` low.
- R4: Operation code 01 (program) sends a frame of 0x06 alone, then a second frame of 0x02, the address and `req_wdata` (40 bits). Operation code 10 (erase) sends a frame of 0x06, then a frame of 0x20 and the address (32 bits). `done_err` is low for both.
- R5: A program or erase whose flat address satisfies base <= addr <= limit for any enabled window asserts no chip select and completes with `done_err` high. A read in the same window runs normally.
- R6: A window whose enable bit is low has no effect on any request.
- R7: The rate is sampled when a request is accepted. A rate of 001 gives clock high and low phases of `HALF_FAST` cycles each. A rate of 000, or any other code, gives `HALF_SLOW` cycles.
- R8: The serial clock is low whenever no chip select is low, and `spi_mosi` does not change while the clock stays high.
- R9: From a chip select falling to the first rising clock edge there are at least `CS_SETUP` cycles, exactly `CS_SETUP` in this design.
- R10: From the last falling clock edge to the chip select rising there are at least `CS_HOLD` cycles, exactly `CS_HOLD` in this design. Between two frames both selects stay high for at least `CS_HOLD` cycles.
- R11: `req_ready` is low while a request is in progress. `done` is a one-cycle pulse. Operation code 11 asserts no chip select and completes with `done_err` high.
- R12: At most one chip select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rate | input | 3 | Serial clock rate select (001 fast, others slow) |
| cfg_split | input | 25 | First flat address that belongs to device 1 |
| prot_en | input | N_RANGES (5) | Enable of each guarded window |
| prot_base | input | 25*N_RANGES | Inclusive lower bound of each window, window i at bits [25i +: 25] |
| prot_limit | input | 25*N_RANGES | Inclusive upper bound of each window, same packing |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 00 read, 01 program byte, 10 erase sector, 11 unsupported |
| req_addr | input | 25 | Flat address |
| req_wdata | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 8 | Read byte, valid with `done` |
| done_err | output | 1 | Request refused, valid with `done` |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 2 | Active-low chip selects, bit i for device i |
| spi_mosi | output | 1 | Serial data to the devices |
| spi_miso | input | 1 | Serial data from the devices |

## Verification
The assertions check the bus timing on every cycle. They cover the select-to-first-edge setup, the last-edge-to-deselect hold, the minimum deselect gap, the minimum high and low clock phases, the clock resting low when idle, the data line holding still while the clock is high, the two selects never being low together, and the handshake rules for `done` and `req_ready`. Other behaviour can only be shown by the bench scenarios, where a flash model captures each frame: the frame contents, the device decode around the split point, the pairing of the write-enable frame with the command frame, the read data path, the window refusals, and the exact phase lengths for each rate code.

// File: rtl/spi_dfm_pkg.sv
package spi_dfm_pkg;

    localparam int ADDR_W     = 25;
    localparam int DEV_ADDR_W = 24;
    localparam int FRAME_W    = 40;
    localparam int NBIT_W     = 6;

    typedef enum logic [1:0] {
        HOST_READ  = 2'b00,
        HOST_WRITE = 2'b01,
        HOST_ERASE = 2'b10,
        HOST_BAD   = 2'b11
    } host_op_e;

    typedef enum logic [2:0] {
        ENG_IDLE, ENG_SETUP, ENG_HIGH, ENG_LOW, ENG_HOLD, ENG_GAP
    } eng_state_e;

    typedef enum logic [1:0] {
        SEQ_IDLE, SEQ_WREN, SEQ_CMD
    } seq_state_e;

    localparam logic [7:0] OPC_READ   = 8'h03;
    localparam logic [7:0] OPC_PROG   = 8'h02;
    localparam logic [7:0] OPC_SERASE = 8'h20;
    localparam logic [7:0] OPC_WREN   = 8'h06;

    localparam logic [2:0] RATE_FAST_CODE = 3'b001;

    // Frame bits are MSB aligned; nbits of them are sent.
    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [NBIT_W-1:0]  nbits;
        logic               dev;
    } frame_t;

    function automatic frame_t cmd_frame(host_op_e op, logic dev,
                                         logic [DEV_ADDR_W-1:0] a, logic [7:0] d);
        frame_t f;
        f.dev = dev;
        case (op)
            HOST_WRITE: begin f.bits = {OPC_PROG, a, d};       f.nbits = 6'd40; end
            HOST_ERASE: begin f.bits = {OPC_SERASE, a, 8'h00}; f.nbits = 6'd32; end
            default:    begin f.bits = {OPC_READ, a, 8'h00};   f.nbits = 6'd40; end
        endcase
        return f;
    endfunction

    function automatic frame_t wren_frame(logic dev);
        frame_t f;
        f.dev   = dev;
        f.bits  = {OPC_WREN, 32'h0};
        f.nbits = 6'd8;
        return f;
    endfunction

endpackage

// File: rtl/sfm_addr_map.sv
module sfm_addr_map
    import spi_dfm_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    input  logic [ADDR_W-1:0]     split,
    output logic                  dev,
    output logic [DEV_ADDR_W-1:0] dev_addr
);
    always_comb begin
        dev      = (addr >= split);
        dev_addr = addr[DEV_ADDR_W-1:0] - (dev ? split[DEV_ADDR_W-1:0] : '0);
    end
endmodule

// File: rtl/sfm_prot_match.sv
module sfm_prot_match
    import spi_dfm_pkg::*;
#(
    parameter int N_RANGES = 5
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [N_RANGES-1:0]        en,
    input  logic [N_RANGES*ADDR_W-1:0] base,
    input  logic [N_RANGES*ADDR_W-1:0] limit,
    output logic                       hit
);
    logic [N_RANGES-1:0] in_range;

    for (genvar i = 0; i < N_RANGES; i++) begin : g_win
        assign in_range[i] = en[i]
                           && (addr >= base[i*ADDR_W +: ADDR_W])
                           && (addr <= limit[i*ADDR_W +: ADDR_W]);
    end

    assign hit = |in_range;
endmodule

// File: rtl/sfm_shift_engine.sv
module sfm_shift_engine
    import spi_dfm_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int CS_SETUP = 6,
    parameter int CS_HOLD  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  frame_t           frm,
    input  logic [CNT_W-1:0] half,
    output logic             fin,
    output logic [7:0]       rx,
    output logic             sclk,
    output logic [1:0]       cs_n,
    output logic             mosi,
    input  logic             miso
);
    eng_state_e         st;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   hreg;
    logic [NBIT_W-1:0]  left;
    logic [FRAME_W-1:0] sh;

    assign mosi = sh[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ENG_IDLE;
            cnt  <= '0;
            hreg <= '0;
            left <= '0;
            sh   <= '0;
            rx   <= '0;
            sclk <= 1'b0;
            cs_n <= 2'b11;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (st)
                ENG_IDLE: if (start) begin
                    sh   <= frm.bits;
                    left <= frm.nbits;
                    hreg <= half;
                    cs_n <= frm.dev ? 2'b01 : 2'b10;
                    cnt  <= '0;
                    st   <= ENG_SETUP;
                end
                ENG_SETUP: if (cnt == CNT_W'(CS_SETUP - 1)) begin
                    sclk <= 1'b1;
                    rx   <= {rx[6:0], miso};
                    cnt  <= '0;
                    st   <= ENG_HIGH;
                end else cnt <= cnt + 1'b1;
                ENG_HIGH: if (cnt == hreg - 1'b1) begin
                    sclk <= 1'b0;
                    cnt  <= '0;
                    left <= left - 1'b1;
                    if (left == NBIT_W'(1)) st <= ENG_HOLD;
                    else begin
                        sh <= sh << 1;
                        st <= ENG_LOW;
                    end
                end else cnt <= cnt + 1'b1;
                ENG_LOW: if (cnt == hreg - 1'b1) begin
                    sclk <= 1'b1;
                    rx   <= {rx[6:0], miso};
                    cnt  <= '0;
                    st   <= ENG_HIGH;
                end else cnt <= cnt + 1'b1;
                ENG_HOLD: if (cnt == CNT_W'(CS_HOLD - 1)) begin
                    cs_n <= 2'b11;
                    cnt  <= '0;
                    st   <= ENG_GAP;
                end else cnt <= cnt + 1'b1;
                ENG_GAP: if (cnt == CNT_W'(CS_HOLD - 1)) begin
                    fin <= 1'b1;
                    cnt <= '0;
                    st  <= ENG_IDLE;
                end else cnt <= cnt + 1'b1;
                default: st <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_dual_flash_master.sv
module spi_dual_flash_master
    import spi_dfm_pkg::*;
#(
    parameter int N_RANGES  = 5,
    parameter int HALF_SLOW = 6,
    parameter int HALF_FAST = 5,
    parameter int CS_SETUP  = 6,
    parameter int CS_HOLD   = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [2:0]                 cfg_rate,
    input  logic [ADDR_W-1:0]          cfg_split,
    input  logic [N_RANGES-1:0]        prot_en,
    input  logic [N_RANGES*ADDR_W-1:0] prot_base,
    input  logic [N_RANGES*ADDR_W-1:0] prot_limit,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [1:0]                 req_op,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [7:0]                 req_wdata,
    output logic                       done,
    output logic [7:0]                 done_rdata,
    output logic                       done_err,
    output logic                       spi_sclk,
    output logic [1:0]                 spi_cs_n,
    output logic                       spi_mosi,
    input  logic                       spi_miso
);
    localparam int MAX_AB = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
    localparam int MAX_CD = (CS_SETUP > CS_HOLD) ? CS_SETUP : CS_HOLD;
    localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    seq_state_e            sq;
    host_op_e              op;
    logic                  dev;
    logic [DEV_ADDR_W-1:0] dev_addr;
    logic                  hit;
    logic                  accept;
    logic                  refuse;
    logic [CNT_W-1:0]      half_sel;
    logic [CNT_W-1:0]      half_q;
    frame_t                frm_q;
    frame_t                cmd_q;
    logic                  start;
    logic                  fin;
    logic [7:0]            rx;
    logic                  is_read_q;

    sfm_addr_map u_map (
        .addr(req_addr), .split(cfg_split), .dev(dev), .dev_addr(dev_addr)
    );

    sfm_prot_match #(.N_RANGES(N_RANGES)) u_prot (
        .addr(req_addr), .en(prot_en), .base(prot_base), .limit(prot_limit), .hit(hit)
    );

    sfm_shift_engine #(.CNT_W(CNT_W), .CS_SETUP(CS_SETUP), .CS_HOLD(CS_HOLD)) u_eng (
        .clk(clk), .rst(rst), .start(start), .frm(frm_q), .half(half_q),
        .fin(fin), .rx(rx), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .miso(spi_miso)
    );

    assign op        = host_op_e'(req_op);
    assign req_ready = (sq == SEQ_IDLE) && !done;
    assign accept    = req_valid && req_ready;
    assign refuse    = (op == HOST_BAD)
                    || (((op == HOST_WRITE) || (op == HOST_ERASE)) && hit);
    assign half_sel  = (cfg_rate == RATE_FAST_CODE) ? CNT_W'(HALF_FAST) : CNT_W'(HALF_SLOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            sq         <= SEQ_IDLE;
            done       <= 1'b0;
            done_err   <= 1'b0;
            done_rdata <= '0;
            start      <= 1'b0;
            frm_q      <= '0;
            cmd_q      <= '0;
            half_q     <= CNT_W'(HALF_SLOW);
            is_read_q  <= 1'b0;
        end else begin
            start <= 1'b0;
            done  <= 1'b0;
            case (sq)
                SEQ_IDLE: if (accept) begin
                    if (refuse) begin
                        done       <= 1'b1;
                        done_err   <= 1'b1;
                        done_rdata <= '0;
                    end else begin
                        half_q    <= half_sel;
                        cmd_q     <= cmd_frame(op, dev, dev_addr, req_wdata);
                        is_read_q <= (op == HOST_READ);
                        start     <= 1'b1;
                        if (op == HOST_READ) begin
                            frm_q <= cmd_frame(op, dev, dev_addr, req_wdata);
                            sq    <= SEQ_CMD;
                        end else begin
                            frm_q <= wren_frame(dev);
                            sq    <= SEQ_WREN;
                        end
                    end
                end
                SEQ_WREN: if (fin) begin
                    frm_q <= cmd_q;
                    start <= 1'b1;
                    sq    <= SEQ_CMD;
                end
                SEQ_CMD: if (fin) begin
                    done       <= 1'b1;
                    done_err   <= 1'b0;
                    done_rdata <= is_read_q ? rx : 8'h00;
                    sq         <= SEQ_IDLE;
                end
                default: sq <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
    parameter int MIN_HALF = 5,
    parameter int CS_SETUP = 6,
    parameter int CS_HOLD  = 6
) (
    input logic       clk,
    input logic       rst,
    input logic       sclk,
    input logic [1:0] cs_n,
    input logic       mosi,
    input logic       req_ready,
    input logic       done
);
    logic        sel;
    logic [15:0] hi_cnt;
    logic [15:0] lo_cnt;
    logic [15:0] desel_cnt;
    logic        seen_rise;

    assign sel = (cs_n != 2'b11);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt    <= '0;
            lo_cnt    <= '0;
            desel_cnt <= '1;
            seen_rise <= 1'b0;
        end else begin
            hi_cnt    <= sclk ? ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1) : '0;
            lo_cnt    <= (sel && !sclk) ? ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1) : '0;
            desel_cnt <= !sel ? ((desel_cnt == '1) ? desel_cnt : desel_cnt + 1'b1) : '0;
            seen_rise <= !sel ? 1'b0 : (sclk ? 1'b1 : seen_rise);
        end
    end

    // R8
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |-> !sclk);

    // R8
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R12
    single_select_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);

    // R7
    high_phase_min_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (hi_cnt >= 16'(MIN_HALF)));

    // R7
    low_phase_min_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sclk) && seen_rise) |-> (lo_cnt >= 16'(MIN_HALF)));

    // R9
    select_setup_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sclk) && !seen_rise) |-> (lo_cnt >= 16'(CS_SETUP)));

    // R10
    select_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sel) |-> (lo_cnt >= 16'(CS_HOLD)));

    // R10
    deselect_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sel) |-> (desel_cnt >= 16'(CS_HOLD)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    ready_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !sel);
endmodule

bind spi_dual_flash_master sfm_checker #(
    .MIN_HALF((HALF_FAST < HALF_SLOW) ? HALF_FAST : HALF_SLOW),
    .CS_SETUP(CS_SETUP),
    .CS_HOLD(CS_HOLD)
) i_sfm_checker (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .req_ready(req_ready), .done(done)
);

// File: tb/test_spi_dual_flash_master.sv
module test_spi_dual_flash_master;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 5;
    localparam int HS = 6;
    localparam int HF = 5;
    localparam int SU = 6;
    localparam int HO = 6;
    localparam logic [24:0] SPLIT = 25'h0100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    cfg_rate = 3'b000;
    logic [24:0]   cfg_split = SPLIT;
    logic [NR-1:0] prot_en = '0;
    logic [NR*25-1:0] prot_base = '0;
    logic [NR*25-1:0] prot_limit = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'b00;
    logic [24:0]   req_addr = '0;
    logic [7:0]    req_wdata = '0;
    logic          done;
    logic [7:0]    done_rdata;
    logic          done_err;
    logic          spi_sclk;
    logic [1:0]    spi_cs_n;
    logic          spi_mosi;
    logic          spi_miso = 1'b0;

    spi_dual_flash_master #(
        .N_RANGES(NR), .HALF_SLOW(HS), .HALF_FAST(HF), .CS_SETUP(SU), .CS_HOLD(HO)
    ) i_spi_dual_flash_master (
        .clk(clk), .rst(rst), .cfg_rate(cfg_rate), .cfg_split(cfg_split),
        .prot_en(prot_en), .prot_base(prot_base), .prot_limit(prot_limit),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
        .done_rdata(done_rdata), .done_err(done_err), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [39:0] bits;
        logic [7:0]  len;
        logic        dev;
        logic [15:0] setup;
        logic [15:0] hold;
        logic [15:0] hi_min;
        logic [15:0] lo_min;
        logic [15:0] gap;
    } frm_t;

    frm_t frames[$];
    frm_t cur;
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    int   run = 0;
    int   desel_run = 1000;
    bit   seen = 1'b0;
    bit   prev_sel = 1'b0;
    bit   prev_sclk = 1'b0;
    bit   prev_mosi = 1'b0;
    int   v_idle_clk = 0;
    int   v_both = 0;
    int   v_ready = 0;
    int   v_mosi = 0;
    logic [7:0] resp [2] = '{8'hA5, 8'h3C};

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Flash-side reference model: captures frames and measures timing each clock.
    always @(negedge clk) begin
        bit sel_now;
        sel_now = (spi_cs_n != 2'b11);
        if (rst) begin
            prev_sel = 0; prev_sclk = 0; desel_run = 1000; spi_miso = 1'b0;
        end else begin
            if (!sel_now && spi_sclk) v_idle_clk++;
            if (spi_cs_n == 2'b00) v_both++;
            if (sel_now && req_ready) v_ready++;
            if (spi_sclk && prev_sclk && (spi_mosi != prev_mosi)) v_mosi++;
            if (sel_now && !prev_sel) begin
                cur = '0;
                cur.dev = spi_cs_n[0];
                cur.gap = 16'(desel_run);
                cur.hi_min = '1;
                cur.lo_min = '1;
                run = 1;
                seen = 0;
            end else if (sel_now) begin
                if (spi_sclk && !prev_sclk) begin
                    if (!seen) cur.setup = 16'(run);
                    else if (16'(run) < cur.lo_min) cur.lo_min = 16'(run);
                    if (cur.len < 40) cur.bits[39 - cur.len] = spi_mosi;
                    cur.len++;
                    seen = 1;
                    run = 1;
                end else if (!spi_sclk && prev_sclk) begin
                    if (16'(run) < cur.hi_min) cur.hi_min = 16'(run);
                    run = 1;
                end else run++;
            end else if (prev_sel) begin
                cur.hold = 16'(run);
                frames.push_back(cur);
                desel_run = 1;
            end else if (desel_run < 1000) desel_run++;
            prev_sel = sel_now;
            prev_sclk = spi_sclk;
            prev_mosi = spi_mosi;
            if (sel_now && cur.len >= 32 && cur.len < 40)
                spi_miso = resp[cur.dev][39 - cur.len];
            else
                spi_miso = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic do_req(input logic [1:0] op, input logic [24:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output logic er);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        rd = done_rdata;
        er = done_err;
        @(negedge clk);
        chk("R11 done single pulse", done, 1'b0);
    endtask

    task automatic set_win(input int i, input logic [24:0] b, input logic [24:0] l, input logic e);
        prot_base[i*25 +: 25] = b;
        prot_limit[i*25 +: 25] = l;
        prot_en[i] = e;
    endtask

    task automatic chk_frame(input string tag, input int idx, input logic dev,
                             input logic [39:0] bits, input int len, input int cmp);
        frm_t f;
        if (idx >= frames.size()) begin
            chk({tag, " frame present"}, 0, 1);
            return;
        end
        f = frames[idx];
        chk({tag, " device"}, f.dev, dev);
        chk({tag, " length"}, f.len, len);
        chk({tag, " bits"}, f.bits >> (40 - cmp), bits >> (40 - cmp));
        chk("R9 setup cycles", f.setup, SU);
        chk("R10 hold cycles", f.hold, HO);
    endtask

    initial begin
        logic [7:0] rd;
        logic er;
        int base;

        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 cs_n in reset", spi_cs_n, 2'b11);
        chk("R1 sclk in reset", spi_sclk, 1'b0);
        chk("R1 done in reset", done, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", req_ready, 1'b1);
        chk("R1 cs_n after reset", spi_cs_n, 2'b11);

        // R2 R3: read on device 0
        base = frames.size();
        do_req(2'b00, 25'h0000ABC, 8'h00, rd, er);
        chk("R3 read frame count", frames.size() - base, 1);
        chk_frame("R3 read dev0", base, 1'b0, {8'h03, 24'h000ABC, 8'h00}, 40, 32);
        chk("R3 read data dev0", rd, 8'hA5);
        chk("R3 read err", er, 1'b0);

        // R2: read on device 1
        base = frames.size();
        do_req(2'b00, 25'h0123456, 8'h00, rd, er);
        chk_frame("R2 read dev1", base, 1'b1, {8'h03, 24'h023456, 8'h00}, 40, 32);
        chk("R3 read data dev1", rd, 8'h3C);

        // R2: boundary on both sides of the split
        base = frames.size();
        do_req(2'b00, SPLIT - 25'd1, 8'h00, rd, er);
        chk_frame("R2 below split", base, 1'b0, {8'h03, 24'h0FFFFF, 8'h00}, 40, 32);
        base = frames.size();
        do_req(2'b00, SPLIT, 8'h00, rd, er);
        chk_frame("R2 at split", base, 1'b1, {8'h03, 24'h000000, 8'h00}, 40, 32);

        // R4: program byte
        base = frames.size();
        do_req(2'b01, 25'h0000100, 8'h5A, rd, er);
        chk("R4 program frame count", frames.size() - base, 2);
        chk_frame("R4 wren before program", base, 1'b0, {8'h06, 32'h0}, 8, 8);
        chk_frame("R4 program", base + 1, 1'b0, {8'h02, 24'h000100, 8'h5A}, 40, 40);
        if (frames.size() >= base + 2)
            chk("R10 deselect gap", frames[base + 1].gap >= HO, 1'b1);
        chk("R4 program err", er, 1'b0);

        // R4: erase on device 1
        base = frames.size();
        do_req(2'b10, SPLIT + 25'h1000, 8'h00, rd, er);
        chk("R4 erase frame count", frames.size() - base, 2);
        chk_frame("R4 wren before erase", base, 1'b1, {8'h06, 32'h0}, 8, 8);
        chk_frame("R4 erase", base + 1, 1'b1, {8'h20, 24'h001000, 8'h00}, 32, 32);

        // R5: guarded windows
        set_win(0, 25'h0002000, 25'h0002FFF, 1'b1);
        set_win(4, 25'h0180000, 25'h018FFFF, 1'b1);
        set_win(2, 25'h0040000, 25'h004FFFF, 1'b0);
        base = frames.size();
        do_req(2'b01, 25'h0002000, 8'h11, rd, er);
        chk("R5 program at window base refused", er, 1'b1);
        do_req(2'b10, 25'h0002FFF, 8'h00, rd, er);
        chk("R5 erase at window limit refused", er, 1'b1);
        do_req(2'b01, 25'h0185000, 8'h22, rd, er);
        chk("R5 program in last window refused", er, 1'b1);
        chk("R5 no bus activity when refused", frames.size() - base, 0);
        base = frames.size();
        do_req(2'b01, 25'h0003000, 8'h33, rd, er);
        chk("R5 program above limit allowed", er, 1'b0);
        do_req(2'b01, 25'h0001FFF, 8'h44, rd, er);
        chk("R5 program below base allowed", er, 1'b0);
        chk("R5 allowed frames", frames.size() - base, 4);
        base = frames.size();
        do_req(2'b00, 25'h0002500, 8'h00, rd, er);
        chk("R5 read in window err", er, 1'b0);
        chk_frame("R5 read in window", base, 1'b0, {8'h03, 24'h002500, 8'h00}, 40, 32);
        chk("R5 read in window data", rd, 8'hA5);

        // R6: disabled window has no effect
        base = frames.size();
        do_req(2'b01, 25'h0044000, 8'h66, rd, er);
        chk("R6 disabled window err", er, 1'b0);
        chk_frame("R6 disabled window program", base + 1, 1'b0, {8'h02, 24'h044000, 8'h66}, 40, 40);

        // R7: rate codes
        base = frames.size();
        do_req(2'b00, 25'h10, 8'h00, rd, er);
        if (frames.size() > base) begin
            chk("R7 rate 000 high phase", frames[base].hi_min, HS);
            chk("R7 rate 000 low phase", frames[base].lo_min, HS);
        end else chk("R7 rate 000 frame", 0, 1);
        cfg_rate = 3'b001;
        base = frames.size();
        do_req(2'b00, 25'h20, 8'h00, rd, er);
        if (frames.size() > base) begin
            chk("R7 rate 001 high phase", frames[base].hi_min, HF);
            chk("R7 rate 001 low phase", frames[base].lo_min, HF);
            chk("R9 setup at fast rate", frames[base].setup, SU);
        end else chk("R7 rate 001 frame", 0, 1);
        chk("R3 read data at fast rate", rd, 8'hA5);
        cfg_rate = 3'b101;
        base = frames.size();
        do_req(2'b10, 25'h30000, 8'h00, rd, er);
        if (frames.size() > base + 1) begin
            chk("R7 rate 101 high phase", frames[base + 1].hi_min, HS);
            chk("R7 rate 101 low phase", frames[base + 1].lo_min, HS);
        end else chk("R7 rate 101 frames", 0, 1);
        cfg_rate = 3'b000;

        // R11: unsupported operation
        base = frames.size();
        do_req(2'b11, 25'h0000040, 8'h00, rd, er);
        chk("R11 unsupported op err", er, 1'b1);
        chk("R11 unsupported op no bus", frames.size() - base, 0);

        repeat (20) @(negedge clk);
        chk("R8 clock low while deselected", v_idle_clk, 0);
        chk("R8 mosi steady while clock high", v_mosi, 0);
        chk("R12 single chip select", v_both, 0);
        chk("R11 ready low while selected", v_ready, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule